// File: doc/BRIEF.md
# Burst Channel Sequencer with Ticket-Locked Shared FIFO Mode

This block is a single channel engine that carries 32-bit words between a coprocessor stream and system memory. Memory is reached through a one-flit-at-a-time request/response port that faces a bus arbiter. The coprocessor side has two streams. One carries words out to the coprocessor, the other takes words in from it. Configuration pins choose the direction and the operating mode.

In buffer mode the engine moves one buffer of the configured byte size as back-to-back bursts. It then raises `done`. In shared-FIFO mode the engine loops without end against a ring buffer that lives in memory. A three-word descriptor describes the ring, and a ticket lock guards it. For each pass the engine does the following in order:
1. It takes a ticket with a read followed by a compare-and-swap.
2. It polls the lock until the lock serves that ticket.
3. It reads the descriptor.
4. It moves one burst if the ring allows it.
5. It writes the descriptor back.
6. It hands the lock on.

Buffer address, buffer size and the ring geometry must all be whole multiples of one burst. Configuration inputs must stay stable while `busy` is high.

Top module: `mwd_chan`

## Requirements
- R1: After reset `busy`, `done`, `req_valid`, `tc_valid` and `fc_ready` are all 0.
- R2: In buffer mode with `cfg_dir`=0, the engine issues size/4 single-flit reads (`req_cmd`=0) at `cfg_buf_addr`+4*i in increasing order. Each response word appears on the `tc_*` stream in the same order.
- R3: In buffer mode with `cfg_dir`=1, each word accepted on the `fc_*` stream is written (`req_cmd`=1) in arrival order to `cfg_buf_addr`+4*i. Exactly size/4 words are written.
- R4: When buffer mode finishes, `done` rises in the cycle after the last response handshake. It stays high, and no new request is issued, while `cfg_run` stays 1. The engine returns to idle in the cycle after `cfg_run` falls.
- R5: A shared-FIFO pass first reads the ticket word at `cfg_lock_addr`. It then sends a compare-and-swap (`req_cmd`=2) to that address with `req_cmp`=ticket and `req_wdata`=ticket+1. The memory returns the prior value. If the returned value differs from the ticket, the pass restarts at the ticket read.
- R6: The engine reads the serving word at `cfg_lock_addr`+4 repeatedly until the value read equals its ticket.
- R7: The descriptor holds three words at `cfg_desc_addr` +0, +4 and +8: the read offset, the write offset and the fill in bytes. With `cfg_dir`=0 and fill >= one burst, the engine reads one burst at `cfg_buf_addr`+read offset. The read offset then advances by one burst and wraps to 0 at the size. The fill drops by one burst, and all three words are written back.
- R8: With `cfg_dir`=1 and size-fill >= one burst, the engine writes one burst at `cfg_buf_addr`+write offset. The write offset advances with the same wrap, the fill grows by one burst, and all three words are written back.
- R9: If the ring lacks one burst of data (`cfg_dir`=0) or of space (`cfg_dir`=1), the pass moves no data and writes no descriptor word. Its only write is the lock release.
- R10: Each pass ends by writing ticket+1 to `cfg_lock_addr`+4.
- R11: `cfg_run` is sampled only when idle. A shared-FIFO pass that has started always runs through its lock release, even if `cfg_run` falls during the pass. Passes repeat while `cfg_run` stays 1.
- R12: At most one request is outstanding. `req_valid` stays low from the request handshake until the matching response handshake. While the outward stream stalls, `rsp_ready` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_run | input | 1 | Enable, sampled when idle |
| cfg_stream | input | 1 | 1 = shared-FIFO mode, 0 = single buffer |
| cfg_dir | input | 1 | 0 = memory to coprocessor, 1 = coprocessor to memory |
| cfg_buf_addr | input | AW | Data buffer byte address |
| cfg_buf_size | input | SZW | Data buffer size in bytes |
| cfg_desc_addr | input | AW | Ring descriptor byte address |
| cfg_lock_addr | input | AW | Lock byte address (ticket at +0, serving at +4) |
| busy | output | 1 | Engine not idle |
| done | output | 1 | Buffer transfer finished, held until run falls |
| req_valid | output | 1 | Request flit valid |
| req_ready | input | 1 | Arbiter accepts the flit |
| req_cmd | output | 2 | 0 read, 1 write, 2 compare-and-swap |
| req_addr | output | AW | Byte address |
| req_wdata | output | 32 | Write or swap data |
| req_cmp | output | 32 | Compare value for swap |
| rsp_valid | input | 1 | Response valid |
| rsp_ready | output | 1 | Response accepted |
| rsp_rdata | input | 32 | Read data, or prior value for swap |
| tc_valid | output | 1 | Word to coprocessor valid |
| tc_ready | input | 1 | Coprocessor accepts word |
| tc_data | output | 32 | Word to coprocessor |
| fc_valid | input | 1 | Word from coprocessor valid, held until taken |
| fc_ready | output | 1 | Engine takes word |
| fc_data | input | 32 | Word from coprocessor |

## Verification
`done` is sampled at the falling edge that follows the posedge where the final response was accepted. The bench also counts how many cycles it stays high. Shared-FIFO results (descriptor words, lock words, moved data) are read from the bench memory only after `busy` falls. That happens one cycle after the release response, so every write of the pass has already landed. The near-exhaustive sweeps cover sizes and offsets, and every expectation is derived from offsets and fills in arithmetic. Request counters in the memory model show the retry and polling behaviour, and `cfg_run` is dropped only on a sampled event such as the second compare-and-swap.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef enum logic [1:0] {CMD_RD = 2'd0, CMD_WR = 2'd1, CMD_CAS = 2'd2} cmd_e;
  typedef enum logic [3:0] {
    ST_IDLE, ST_TRD, ST_CAS, ST_LRD, ST_SRD, ST_EVAL, ST_DATA, ST_SWR, ST_REL, ST_HALT
  } st_e;
endpackage

// File: rtl/mwd_beat_ctr.sv
module mwd_beat_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mwd_ring_calc.sv
module mwd_ring_calc #(
  parameter int SZW = 16,
  parameter int BB  = 16
) (
  input  logic           dir,
  input  logic [SZW-1:0] size,
  input  logic [SZW-1:0] rptr,
  input  logic [SZW-1:0] wptr,
  input  logic [SZW-1:0] fill,
  output logic           ok,
  output logic [SZW-1:0] off,
  output logic [SZW-1:0] nrptr,
  output logic [SZW-1:0] nwptr,
  output logic [SZW-1:0] nfill
);
  localparam logic [SZW:0] BBW = (SZW+1)'(BB);

  logic [SZW:0] room;
  logic [SZW:0] r_adv, w_adv;

  assign room  = {1'b0, size} - {1'b0, fill};
  assign r_adv = {1'b0, rptr} + BBW;
  assign w_adv = {1'b0, wptr} + BBW;

  always_comb begin
    nrptr = rptr;
    nwptr = wptr;
    if (!dir) begin
      ok    = ({1'b0, fill} >= BBW);
      off   = rptr;
      nrptr = (r_adv >= {1'b0, size}) ? '0 : r_adv[SZW-1:0];
      nfill = fill - BBW[SZW-1:0];
    end else begin
      ok    = (fill <= size) && (room >= BBW);
      off   = wptr;
      nwptr = (w_adv >= {1'b0, size}) ? '0 : w_adv[SZW-1:0];
      nfill = fill + BBW[SZW-1:0];
    end
  end
endmodule

// File: rtl/mwd_chan.sv
module mwd_chan
  import mwd_pkg::*;
#(
  parameter int AW          = 32,
  parameter int SZW         = 16,
  parameter int BURST_WORDS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_run,
  input  logic           cfg_stream,
  input  logic           cfg_dir,
  input  logic [AW-1:0]  cfg_buf_addr,
  input  logic [SZW-1:0] cfg_buf_size,
  input  logic [AW-1:0]  cfg_desc_addr,
  input  logic [AW-1:0]  cfg_lock_addr,
  output logic           busy,
  output logic           done,
  output logic           req_valid,
  input  logic           req_ready,
  output logic [1:0]     req_cmd,
  output logic [AW-1:0]  req_addr,
  output logic [31:0]    req_wdata,
  output logic [31:0]    req_cmp,
  input  logic           rsp_valid,
  output logic           rsp_ready,
  input  logic [31:0]    rsp_rdata,
  output logic           tc_valid,
  input  logic           tc_ready,
  output logic [31:0]    tc_data,
  input  logic           fc_valid,
  output logic           fc_ready,
  input  logic [31:0]    fc_data
);
  localparam int BB   = BURST_WORDS * 4;
  localparam int MAXB = (BURST_WORDS > 3) ? BURST_WORDS : 3;
  localparam int CW   = $clog2(MAXB) + 1;
  localparam logic [SZW:0] BBW = (SZW+1)'(BB);

  st_e            state;
  logic           wait_rsp, held, lat_mode, lat_dir;
  logic [31:0]    ticket;
  logic [SZW-1:0] rptr, wptr, fill, xoff;
  logic [CW-1:0]  beat;
  logic           req_fire, rsp_fire, beat_last, multi, data_st, v;
  logic [AW-1:0]  boff;
  cmd_e           cmd;
  logic           c_ok;
  logic [SZW-1:0] c_off, c_nr, c_nw, c_nf;

  assign req_fire  = req_valid && req_ready;
  assign rsp_fire  = rsp_valid && rsp_ready;
  assign data_st   = (state == ST_DATA);
  assign multi     = data_st || (state == ST_SRD) || (state == ST_SWR);
  assign beat_last = data_st ? (beat == CW'(BURST_WORDS - 1)) : (beat == CW'(2));
  assign boff      = AW'(beat) << 2;

  mwd_beat_ctr #(.W(CW)) u_beat (
    .clk(clk), .rst_n(rst_n),
    .clr((state == ST_IDLE) || (rsp_fire && multi && beat_last)),
    .inc(rsp_fire && multi),
    .cnt(beat)
  );

  mwd_ring_calc #(.SZW(SZW), .BB(BB)) u_calc (
    .dir(lat_dir), .size(cfg_buf_size), .rptr(rptr), .wptr(wptr), .fill(fill),
    .ok(c_ok), .off(c_off), .nrptr(c_nr), .nwptr(c_nw), .nfill(c_nf)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wait_rsp <= 1'b0;
      held     <= 1'b0;
      lat_mode <= 1'b0;
      lat_dir  <= 1'b0;
      ticket   <= '0;
      rptr     <= '0;
      wptr     <= '0;
      fill     <= '0;
      xoff     <= '0;
    end else begin
      if (req_fire) wait_rsp <= 1'b1;
      if (rsp_fire) wait_rsp <= 1'b0;
      case (state)
        ST_IDLE: if (cfg_run) begin
          lat_mode <= cfg_stream;
          lat_dir  <= cfg_dir;
          xoff     <= '0;
          if (cfg_stream)             state <= ST_TRD;
          else if (cfg_buf_size == 0) state <= ST_HALT;
          else                        state <= ST_DATA;
        end
        ST_TRD: if (rsp_fire) begin
          ticket <= rsp_rdata;
          state  <= ST_CAS;
        end
        ST_CAS: if (rsp_fire) state <= (rsp_rdata == ticket) ? ST_LRD : ST_TRD;
        ST_LRD: if (rsp_fire && rsp_rdata == ticket) begin
          held  <= 1'b1;
          state <= ST_SRD;
        end
        ST_SRD: if (rsp_fire) begin
          case (beat)
            CW'(0):  rptr <= rsp_rdata[SZW-1:0];
            CW'(1):  wptr <= rsp_rdata[SZW-1:0];
            default: begin
              fill  <= rsp_rdata[SZW-1:0];
              state <= ST_EVAL;
            end
          endcase
        end
        ST_EVAL: if (c_ok) begin
          xoff  <= c_off;
          rptr  <= c_nr;
          wptr  <= c_nw;
          fill  <= c_nf;
          state <= ST_DATA;
        end else begin
          state <= ST_REL;
        end
        ST_DATA: if (rsp_fire && beat_last) begin
          if (lat_mode) state <= ST_SWR;
          else if (({1'b0, xoff} + BBW) == {1'b0, cfg_buf_size}) state <= ST_HALT;
          else xoff <= xoff + BBW[SZW-1:0];
        end
        ST_SWR: if (rsp_fire && beat_last) state <= ST_REL;
        ST_REL: if (rsp_fire) begin
          held  <= 1'b0;
          state <= ST_IDLE;
        end
        ST_HALT: if (!cfg_run) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    v         = 1'b0;
    cmd       = CMD_RD;
    req_addr  = cfg_lock_addr;
    req_wdata = '0;
    req_cmp   = '0;
    case (state)
      ST_TRD: v = 1'b1;
      ST_CAS: begin
        v = 1'b1; cmd = CMD_CAS; req_cmp = ticket; req_wdata = ticket + 1;
      end
      ST_LRD: begin v = 1'b1; req_addr = cfg_lock_addr + AW'(4); end
      ST_SRD: begin v = 1'b1; req_addr = cfg_desc_addr + boff; end
      ST_DATA: begin
        v         = lat_dir ? fc_valid : 1'b1;
        cmd       = lat_dir ? CMD_WR : CMD_RD;
        req_addr  = cfg_buf_addr + AW'(xoff) + boff;
        req_wdata = fc_data;
      end
      ST_SWR: begin
        v = 1'b1; cmd = CMD_WR; req_addr = cfg_desc_addr + boff;
        case (beat)
          CW'(0):  req_wdata = {{(32-SZW){1'b0}}, rptr};
          CW'(1):  req_wdata = {{(32-SZW){1'b0}}, wptr};
          default: req_wdata = {{(32-SZW){1'b0}}, fill};
        endcase
      end
      ST_REL: begin
        v = 1'b1; cmd = CMD_WR; req_addr = cfg_lock_addr + AW'(4); req_wdata = ticket + 1;
      end
      default: v = 1'b0;
    endcase
  end

  assign req_valid = v && !wait_rsp;
  assign req_cmd   = cmd;
  assign fc_ready  = data_st && lat_dir && !wait_rsp && req_ready;
  assign tc_valid  = data_st && !lat_dir && wait_rsp && rsp_valid;
  assign tc_data   = rsp_rdata;
  assign rsp_ready = wait_rsp && !(data_st && !lat_dir && !tc_ready);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_HALT);

  // R12
  one_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_valid);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !(data_st && lat_dir)) |=>
      (req_valid && $stable(req_addr) && $stable(req_cmd)));
  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(rsp_fire) || $past(cfg_buf_size) == 0));
  // R11
  idle_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !held);
  // R2
  tc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_valid |-> (rsp_valid && !lat_dir));
endmodule

// File: tb/sim_mwd_chan.sv
module sim_mwd_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cfg_run = 0, cfg_stream = 0, cfg_dir = 0;
  logic [31:0] cfg_buf_addr = 0, cfg_desc_addr = 32'h10, cfg_lock_addr = 32'h0;
  logic [15:0] cfg_buf_size = 0;
  logic busy, done, req_valid, req_ready, rsp_valid, rsp_ready, tc_valid, tc_ready, fc_valid, fc_ready;
  logic [1:0]  req_cmd;
  logic [31:0] req_addr, req_wdata, req_cmp, rsp_rdata, tc_data, fc_data;

  mwd_chan u0 (.*);

  int checks = 0, errors = 0;
  int cyc = 0;
  int rdy_mode = 0, src_mode = 0, rq_mode = 0;
  logic [31:0] mem [256];
  logic [31:0] got [64];
  int ngot, cnt_rd, cnt_wr, cnt_cas, cnt_lrd, done_cyc;
  int spin_left, cas_left;
  logic [31:0] spin_tgt;
  logic        pk_en = 0, ld = 0;
  logic [7:0]  pk_idx = 0;
  logic [31:0] pk_val = 0, k_seed = 0, k_tgt = 0;
  int          k_spin = 0, k_cas = 0;

  assign tc_ready  = (rdy_mode == 0) || (cyc % rdy_mode != 0);
  assign req_ready = (rq_mode == 0) || (cyc % rq_mode != 0);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pk_en) mem[pk_idx] <= pk_val;
    if (ld) begin
      ngot <= 0; cnt_rd <= 0; cnt_wr <= 0; cnt_cas <= 0; cnt_lrd <= 0; done_cyc <= 0;
      spin_left <= k_spin; cas_left <= k_cas; spin_tgt <= k_tgt;
      fc_data <= k_seed; fc_valid <= 1'b0;
    end else begin
      if (done) done_cyc <= done_cyc + 1;
      if (tc_valid && tc_ready) begin got[ngot[5:0]] <= tc_data; ngot <= ngot + 1; end
      if (fc_valid && fc_ready) begin
        fc_data <= fc_data + 1; fc_valid <= (src_mode == 0) || (cyc % src_mode != 0);
      end else if (!fc_valid) fc_valid <= (src_mode == 0) || (cyc % src_mode != 0);
    end
    if (!rst_n) rsp_valid <= 1'b0;
    else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
        rsp_valid <= 1'b1;
        case (req_cmd)
          2'd0: begin
            cnt_rd <= cnt_rd + 1;
            rsp_rdata <= mem[req_addr[9:2]];
            if (req_addr[9:2] == 8'd1) begin
              cnt_lrd <= cnt_lrd + 1;
              if (spin_left != 0) begin
                spin_left <= spin_left - 1;
                if (spin_left == 1) mem[1] <= spin_tgt;
              end
            end
          end
          2'd1: begin
            cnt_wr <= cnt_wr + 1; rsp_rdata <= 0; mem[req_addr[9:2]] <= req_wdata;
          end
          default: begin
            cnt_cas <= cnt_cas + 1;
            if (cas_left != 0) begin
              cas_left <= cas_left - 1;
              mem[req_addr[9:2]] <= mem[req_addr[9:2]] + 1;
              rsp_rdata <= mem[req_addr[9:2]] + 1;
            end else begin
              rsp_rdata <= mem[req_addr[9:2]];
              if (mem[req_addr[9:2]] == req_cmp) mem[req_addr[9:2]] <= req_wdata;
            end
          end
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    @(negedge clk); pk_en = 1; pk_idx = 8'(idx); pk_val = val;
    @(negedge clk); pk_en = 0;
  endtask

  task automatic load(input logic [31:0] seed, input int spin, input int cas, input logic [31:0] tgt);
    @(negedge clk); ld = 1; k_seed = seed; k_spin = spin; k_cas = cas; k_tgt = tgt;
    @(negedge clk); ld = 0;
  endtask

  task automatic pulse_run(input logic stream, input logic dir, input int size, input logic [31:0] base);
    @(negedge clk);
    cfg_stream = stream; cfg_dir = dir; cfg_buf_size = 16'(size); cfg_buf_addr = base; cfg_run = 1;
    @(negedge clk); cfg_run = 0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(tag, (n < 5000) ? 32'd1 : 32'd0, 32'd1);
  endtask

  task automatic mw_setup(input logic [31:0] t, input int r, input int w, input int f);
    poke(0, t); poke(1, t); poke(4, r); poke(5, w); poke(6, f);
    for (int i = 0; i < 16; i++) poke(64 + i, 32'hC000_0000 + i);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    logic [31:0] t, nr, nw, nf;
    logic ok;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 req_valid", {31'd0, req_valid}, 0);
    chk("R1 tc_valid", {31'd0, tc_valid}, 0);
    chk("R1 fc_ready", {31'd0, fc_ready}, 0);

    // R2 buffer mode to coprocessor, sizes and stall patterns
    for (int sz = 16; sz <= 64; sz += 16)
      for (int rm = 0; rm < 2; rm++) begin
        rdy_mode = rm * 3; rq_mode = rm * 2;
        for (int i = 0; i < sz / 4; i++) poke(128 + i, 32'hD000_0000 + sz * 256 + i * 3 + rm);
        load(0, 0, 0, 0);
        pulse_run(0, 0, sz, 32'h200);
        wait_idle("R2 idle");
        chk("R2 word count", ngot, sz / 4);
        chk("R2 read count", cnt_rd, sz / 4);
        for (int i = 0; i < sz / 4; i++) chk("R2 word", got[i], 32'hD000_0000 + sz * 256 + i * 3 + rm);
        chk("R4 done pulse", done_cyc, 1);
      end
    rdy_mode = 0; rq_mode = 0;

    // R3 buffer mode from coprocessor
    for (int sz = 16; sz <= 64; sz += 16)
      for (int sm = 0; sm < 2; sm++) begin
        src_mode = sm * 2;
        load(32'hF000_0000 + sz * 16 + sm, 0, 0, 0);
        pulse_run(0, 1, sz, 32'h200);
        wait_idle("R3 idle");
        chk("R3 write count", cnt_wr, sz / 4);
        for (int i = 0; i < sz / 4; i++) chk("R3 word", mem[128 + i], 32'hF000_0000 + sz * 16 + sm + i);
      end
    src_mode = 0;

    // R4 done held while run stays high
    load(0, 0, 0, 0);
    @(negedge clk); cfg_stream = 0; cfg_dir = 0; cfg_buf_size = 32; cfg_buf_addr = 32'h200; cfg_run = 1;
    nb = 0;
    while (!done && nb < 1000) begin @(negedge clk); nb++; end
    t = cnt_rd;
    repeat (5) @(negedge clk);
    chk("R4 done held", {31'd0, done}, 1);
    chk("R4 no restart", cnt_rd, t);
    cfg_run = 0;
    @(negedge clk);
    chk("R4 idle after run low", {31'd0, busy}, 0);

    // R7 R9 R10 consumer sweep
    for (int r = 0; r < 64; r += 16)
      for (int f = 0; f <= 64; f += 16) begin
        t = 32'd5 + r + f;
        mw_setup(t, r, (r + f) % 64, f);
        load(0, 0, 0, 0);
        pulse_run(1, 0, 64, 32'h100);
        wait_idle("R7 idle");
        ok = (f >= 16);
        nr = ok ? ((r + 16 == 64) ? 0 : r + 16) : r;
        nf = ok ? f - 16 : f;
        chk("R7 rptr", mem[4], nr);
        chk("R7 wptr", mem[5], (r + f) % 64);
        chk("R7 fill", mem[6], nf);
        chk("R7 words", ngot, ok ? 4 : 0);
        if (ok) for (int i = 0; i < 4; i++) chk("R7 data", got[i], 32'hC000_0000 + r / 4 + i);
        chk("R9 writes", cnt_wr, ok ? 4 : 1);
        chk("R10 release", mem[1], t + 1);
        chk("R5 ticket", mem[0], t + 1);
      end

    // R8 R9 producer sweep
    for (int w = 0; w < 64; w += 16)
      for (int f = 0; f <= 64; f += 16) begin
        t = 32'd100 + w + f;
        mw_setup(t, (w + 64 - f) % 64, w, f);
        load(32'hB000_0000 + w * 64 + f, 0, 0, 0);
        pulse_run(1, 1, 64, 32'h100);
        wait_idle("R8 idle");
        ok = (64 - f >= 16);
        nw = ok ? ((w + 16 == 64) ? 0 : w + 16) : w;
        nf = ok ? f + 16 : f;
        chk("R8 wptr", mem[5], nw);
        chk("R8 fill", mem[6], nf);
        chk("R8 rptr", mem[4], (w + 64 - f) % 64);
        for (int i = 0; i < 4; i++)
          chk("R8 data", mem[64 + w / 4 + i], ok ? 32'hB000_0000 + w * 64 + f + i : 32'hC000_0000 + w / 4 + i);
        chk("R9 writes", cnt_wr, ok ? 8 : 1);
        chk("R10 release", mem[1], t + 1);
      end

    // R5 R6 failed swap then lock polling
    mw_setup(20, 0, 16, 16);
    load(0, 3, 1, 21);
    pulse_run(1, 0, 64, 32'h100);
    wait_idle("R5 idle");
    chk("R5 swap count", cnt_cas, 2);
    chk("R5 ticket word", mem[0], 22);
    chk("R6 lock reads", cnt_lrd, 4);
    chk("R6 total reads", cnt_rd, 13);
    chk("R10 release after retry", mem[1], 22);
    chk("R7 data after retry", ngot, 4);

    // R11 continuous passes, stop requested mid-pass
    mw_setup(40, 0, 48, 48);
    load(0, 0, 0, 0);
    @(negedge clk); cfg_stream = 1; cfg_dir = 0; cfg_buf_size = 64; cfg_buf_addr = 32'h100; cfg_run = 1;
    nb = 0;
    while (cnt_cas < 2 && nb < 2000) begin @(negedge clk); nb++; end
    cfg_run = 0;
    @(negedge clk);
    wait_idle("R11 idle");
    chk("R11 passes fill", mem[6], 16);
    chk("R11 passes rptr", mem[4], 32);
    chk("R11 lock balanced", mem[1], 42);
    chk("R11 ticket", mem[0], 42);
    chk("R11 words", ngot, 8);
    for (int i = 0; i < 8; i++) chk("R11 data", got[i], 32'hC000_0000 + i);
    repeat (4) @(negedge clk);
    chk("R11 stays idle", {31'd0, busy}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule